// File: doc/BRIEF.md
# Memory Request Admission Queue

This block sits in front of a memory controller and decides what happens to each request from a single requester. A request arrives on a valid/ready channel carrying an address, a direction bit and a byte count. The block either takes it into one of two address queues (reads or writes), answers it on the spot, throws it away, or refuses it by holding `req_ready` low and remembering that the requester is owed a retry. The controller behind the block pulls read addresses out of the read queue into a response stage, tells the block when a response-stage slot has been freed, and pulls write addresses out of the write queue.

Reads are counted against one shared budget: addresses still waiting in the read queue plus reads already moved into the response stage. Before a read is queued, its burst-aligned address is compared with every write still held. On a match the read is answered at once through `fwd_hit` and never occupies read space. Writes are acknowledged as soon as they are queued. Requests with the inhibit flag are consumed silently. Requests with a zero byte count or more bytes than one burst are consumed and reported on `req_err`.

Each request falls into exactly one admission kind: ADM_DROP_INHIBIT, ADM_DROP_ILLEGAL, ADM_FORWARD, ADM_ENQ_RD, ADM_ENQ_WR, ADM_REFUSE_RD or ADM_REFUSE_WR. A two-state machine governs write draining. In WQ_FILL, `drain_req` is low. The transition WQ_FILL to WQ_DRAIN is taken when the write count is above `WR_THRESH` and `reads_paused` is low. In WQ_DRAIN, `drain_req` is high. The transition WQ_DRAIN to WQ_FILL is taken once the write queue is empty.

Top module: `mem_admit_queue`

## Requirements
- R1: When read-queue entries plus response-stage entries equal `RD_DEPTH`, a legal read with no write match sees `req_ready` low.
- R2: When the write queue holds `WR_DEPTH` entries, a legal write sees `req_ready` low.
- R3: A refused request is not lost. `req_ready` stays low while the condition lasts, the refusal is remembered (read and write separately), and the same request is taken once room exists.
- R4: A legal read (`req_is_write`=0) whose address bits above log2(`BURST_BYTES`) equal those of any queued write is accepted even when the read side is full. It raises `fwd_hit` for one cycle after the handshake and adds nothing to the read queue.
- R5: A legal write (`req_is_write`=1) that is accepted raises `wr_ack` for one cycle after the handshake and appears in the write queue.
- R6: If the write count exceeds `WR_THRESH` while `reads_paused` is low, `drain_req` rises within two cycles. It then stays high until the write queue is empty, and falls within two cycles of that. While `reads_paused` is high, no drain starts.
- R7: A request with `req_size` of 0 or greater than `BURST_BYTES` is accepted, pulses `req_err` one cycle later, and enters neither queue.
- R8: A `resp_free` with a remembered read refusal and a non-empty response stage pulses `rd_retry` one cycle later and clears the refusal. A later `resp_free` with no new refusal gives no pulse.
- R9: A request with `req_inhibit` high is accepted and produces no `wr_ack`, `fwd_hit` or `req_err`, and it enters neither queue.
- R10: A `wrq_pop` on a non-empty write queue with a remembered write refusal pulses `wr_retry` one cycle later.
- R11: Both queues present addresses at their heads in arrival order.
- R12: After reset both queues are empty, `drain_req` and all pulse outputs are low, and a legal write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high together with valid |
| req_addr | input | AW | Byte address |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_size | input | log2(BURST_BYTES)+2 | Byte count |
| req_inhibit | input | 1 | Request to be consumed silently |
| reads_paused | input | 1 | Blocks the start of a write drain |
| rdq_valid | output | 1 | Read queue not empty |
| rdq_addr | output | AW | Oldest queued read address |
| rdq_pop | input | 1 | Move the oldest read into the response stage |
| resp_free | input | 1 | One response-stage slot freed |
| wrq_valid | output | 1 | Write queue not empty |
| wrq_addr | output | AW | Oldest queued write address |
| wrq_pop | input | 1 | Remove the oldest write |
| wr_ack | output | 1 | Write queued (pulse) |
| fwd_hit | output | 1 | Read answered from the write queue (pulse) |
| req_err | output | 1 | Illegal size consumed (pulse) |
| rd_retry | output | 1 | Read may be retried (pulse) |
| wr_retry | output | 1 | Write may be retried (pulse) |
| drain_req | output | 1 | Write drain requested |

## Verification
The hardest situation to reach is a read refusal that is still pending when a response-stage slot frees. Reaching it requires that the read budget be filled partly by queued reads and partly by reads already moved into the response stage, that a refusal happen, and that no later accepted request clear the refusal before `resp_free` arrives. The stimulus fills the read side with distinct addresses and probes a forwarded read while the side is still full, before any refusal exists. It then refuses a read, moves one read to the response stage (occupancy unchanged, the same read still refused), and only then frees the slot.

// File: rtl/adm_pkg.sv
package adm_pkg;

    typedef enum logic [2:0] {
        ADM_DROP_INHIBIT,
        ADM_DROP_ILLEGAL,
        ADM_FORWARD,
        ADM_ENQ_RD,
        ADM_ENQ_WR,
        ADM_REFUSE_RD,
        ADM_REFUSE_WR
    } adm_kind_e;

    typedef enum logic {
        WQ_FILL,
        WQ_DRAIN
    } wq_state_e;

endpackage

// File: rtl/adm_addr_ring.sv
module adm_addr_ring #(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic          head_vld,
    output logic [AW-1:0] head_addr,
    output logic [CW-1:0] count
);
    logic [AW-1:0] slot_q [DEPTH];
    logic [PW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (do_push) slot_q[wr_ptr_q] <= push_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= step(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= step(rd_ptr_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign head_vld  = (cnt_q != '0);
    assign head_addr = slot_q[rd_ptr_q];
    assign count     = cnt_q;

    // R11: order is only kept if nothing is pushed into a full ring
    assert_ring_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q != CW'(DEPTH)));

endmodule

// File: rtl/adm_write_cam.sv
module adm_write_cam #(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    parameter int OFFW  = 6,
    localparam int LW   = AW - OFFW,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    input  logic [LW-1:0] probe_line,
    output logic          probe_hit,
    output logic          head_vld,
    output logic [AW-1:0] head_addr,
    output logic [CW-1:0] count
);
    logic [AW-1:0]    slot_q [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic [DEPTH-1:0] hit_vec;
    logic [PW-1:0]    rd_ptr_q, wr_ptr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (do_push) slot_q[wr_ptr_q] <= push_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
            live_q   <= '0;
        end else begin
            if (do_pop)  live_q[rd_ptr_q] <= 1'b0;
            if (do_push) live_q[wr_ptr_q] <= 1'b1;
            if (do_push) wr_ptr_q <= step(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= step(rd_ptr_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = live_q[i] && (slot_q[i][AW-1:OFFW] == probe_line);
    end

    assign probe_hit = |hit_vec;
    assign head_vld  = (cnt_q != '0);
    assign head_addr = slot_q[rd_ptr_q];
    assign count     = cnt_q;

    // R2: the write queue is never pushed beyond its depth
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q != CW'(DEPTH)));

    // R4: the number of live slots tracks the count
    assert_live_matches_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(live_q) == int'(cnt_q));

endmodule

// File: rtl/adm_drain_fsm.sv
module adm_drain_fsm
    import adm_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int THRESH = 5,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wq_count,
    input  logic          reads_paused,
    output logic          drain_req
);
    wq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WQ_FILL:  if (wq_count > CW'(THRESH) && !reads_paused) state_d = WQ_DRAIN;
            WQ_DRAIN: if (wq_count == '0) state_d = WQ_FILL;
            default:  state_d = WQ_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WQ_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            WQ_DRAIN: drain_req = 1'b1;
            default:  drain_req = 1'b0;
        endcase
    end

    // R6: crossing the threshold with reads running starts a drain
    assert_drain_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WQ_FILL && wq_count > CW'(THRESH) && !reads_paused) |=> drain_req);

    // R6: a drain never ends with writes still queued
    assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && wq_count != '0) |=> drain_req);

endmodule

// File: rtl/mem_admit_queue.sv
module mem_admit_queue
    import adm_pkg::*;
#(
    parameter int AW          = 32,
    parameter int BURST_BYTES = 64,
    parameter int RD_DEPTH    = 8,
    parameter int WR_DEPTH    = 8,
    parameter int WR_THRESH   = 5,
    localparam int SZW        = $clog2(BURST_BYTES) + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic           req_is_write,
    input  logic [SZW-1:0] req_size,
    input  logic           req_inhibit,
    input  logic           reads_paused,
    output logic           rdq_valid,
    output logic [AW-1:0]  rdq_addr,
    input  logic           rdq_pop,
    input  logic           resp_free,
    output logic           wrq_valid,
    output logic [AW-1:0]  wrq_addr,
    input  logic           wrq_pop,
    output logic           wr_ack,
    output logic           fwd_hit,
    output logic           req_err,
    output logic           rd_retry,
    output logic           wr_retry,
    output logic           drain_req
);
    localparam int OFFW = $clog2(BURST_BYTES);
    localparam int RCW  = $clog2(RD_DEPTH + 1);
    localparam int WCW  = $clog2(WR_DEPTH + 1);

    adm_kind_e     kind;
    logic          fire, size_bad, wq_hit, rd_full, wr_full;
    logic          rq_push, wq_push, clr_flags;
    logic          rd_flag_q, wr_flag_q, rd_retry_go, wr_retry_go;
    logic [RCW-1:0] rq_cnt, resp_cnt_q, rd_occ;
    logic [WCW-1:0] wq_cnt;

    assign size_bad = (req_size == '0) || (req_size > SZW'(BURST_BYTES));
    assign rd_occ   = rq_cnt + resp_cnt_q;
    assign rd_full  = (rd_occ == RCW'(RD_DEPTH));
    assign wr_full  = (wq_cnt == WCW'(WR_DEPTH));

    // admission decision
    always_comb begin
        if (req_inhibit)       kind = ADM_DROP_INHIBIT;
        else if (size_bad)     kind = ADM_DROP_ILLEGAL;
        else if (req_is_write) kind = wr_full ? ADM_REFUSE_WR : ADM_ENQ_WR;
        else if (wq_hit)       kind = ADM_FORWARD;
        else                   kind = rd_full ? ADM_REFUSE_RD : ADM_ENQ_RD;
    end

    always_comb begin
        unique case (kind)
            ADM_REFUSE_RD, ADM_REFUSE_WR: req_ready = 1'b0;
            default:                      req_ready = 1'b1;
        endcase
    end

    assign fire      = req_valid && req_ready;
    assign rq_push   = fire && (kind == ADM_ENQ_RD);
    assign wq_push   = fire && (kind == ADM_ENQ_WR);
    assign clr_flags = fire && (kind == ADM_ENQ_RD || kind == ADM_ENQ_WR || kind == ADM_FORWARD);

    assign rd_retry_go = resp_free && (resp_cnt_q != '0) && rd_flag_q;
    assign wr_retry_go = wrq_pop && (wq_cnt != '0) && wr_flag_q;

    adm_addr_ring #(.AW(AW), .DEPTH(RD_DEPTH)) u_rd_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rq_push),
        .push_addr (req_addr),
        .pop       (rdq_pop),
        .head_vld  (rdq_valid),
        .head_addr (rdq_addr),
        .count     (rq_cnt)
    );

    adm_write_cam #(.AW(AW), .DEPTH(WR_DEPTH), .OFFW(OFFW)) u_wr_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wq_push),
        .push_addr  (req_addr),
        .pop        (wrq_pop),
        .probe_line (req_addr[AW-1:OFFW]),
        .probe_hit  (wq_hit),
        .head_vld   (wrq_valid),
        .head_addr  (wrq_addr),
        .count      (wq_cnt)
    );

    adm_drain_fsm #(.DEPTH(WR_DEPTH), .THRESH(WR_THRESH)) u_drain (
        .clk          (clk),
        .rst_n        (rst_n),
        .wq_count     (wq_cnt),
        .reads_paused (reads_paused),
        .drain_req    (drain_req)
    );

    // response-stage occupancy, refusal memory and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_cnt_q <= '0;
            rd_flag_q  <= 1'b0;
            wr_flag_q  <= 1'b0;
            wr_ack     <= 1'b0;
            fwd_hit    <= 1'b0;
            req_err    <= 1'b0;
            rd_retry   <= 1'b0;
            wr_retry   <= 1'b0;
        end else begin
            resp_cnt_q <= resp_cnt_q + RCW'(rdq_pop && rdq_valid)
                                     - RCW'(resp_free && resp_cnt_q != '0);
            if (req_valid && kind == ADM_REFUSE_RD) rd_flag_q <= 1'b1;
            else if (clr_flags || rd_retry_go)      rd_flag_q <= 1'b0;
            if (req_valid && kind == ADM_REFUSE_WR) wr_flag_q <= 1'b1;
            else if (clr_flags || wr_retry_go)      wr_flag_q <= 1'b0;
            wr_ack   <= wq_push;
            fwd_hit  <= fire && (kind == ADM_FORWARD);
            req_err  <= fire && (kind == ADM_DROP_ILLEGAL);
            rd_retry <= rd_retry_go;
            wr_retry <= wr_retry_go;
        end
    end

    // R1: the shared read budget is never exceeded
    assert_rd_budget_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_occ) <= RD_DEPTH);

    // R3: a refused read is remembered
    assert_refuse_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !req_is_write) |=> rd_flag_q);

    // R4: a forwarded read is answered on the next cycle
    assert_forward_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && kind == ADM_FORWARD) |=> fwd_hit);

    // R5: a queued write is acknowledged on the next cycle
    assert_write_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wq_push |=> wr_ack);

    // R9: an inhibited request leaves no trace on the pulses
    assert_inhibit_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_inhibit) |=> (!wr_ack && !fwd_hit && !req_err));

    // R8: a read retry is only signalled for a remembered refusal
    assert_retry_owed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_retry |-> $past(rd_flag_q));

    // R10: a write retry is only signalled for a remembered refusal
    assert_wretry_owed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_retry |-> $past(wr_flag_q));

endmodule

// File: tb/mem_admit_queue_tb_top.sv
module mem_admit_queue_tb_top;
    localparam int AW    = 16;
    localparam int BURST = 16;
    localparam int RDD   = 4;
    localparam int WRD   = 4;
    localparam int THR   = 2;
    localparam int SZW   = $clog2(BURST) + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_write = 1'b0, req_inhibit = 1'b0, reads_paused = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SZW-1:0] req_size = '0;
    logic rdq_pop = 1'b0, resp_free = 1'b0, wrq_pop = 1'b0;
    logic req_ready, rdq_valid, wrq_valid, wr_ack, fwd_hit, req_err, rd_retry, wr_retry, drain_req;
    logic [AW-1:0] rdq_addr, wrq_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mem_admit_queue #(.AW(AW), .BURST_BYTES(BURST), .RD_DEPTH(RDD),
                      .WR_DEPTH(WRD), .WR_THRESH(THR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_is_write(req_is_write), .req_size(req_size),
        .req_inhibit(req_inhibit), .reads_paused(reads_paused),
        .rdq_valid(rdq_valid), .rdq_addr(rdq_addr), .rdq_pop(rdq_pop),
        .resp_free(resp_free), .wrq_valid(wrq_valid), .wrq_addr(wrq_addr),
        .wrq_pop(wrq_pop), .wr_ack(wr_ack), .fwd_hit(fwd_hit), .req_err(req_err),
        .rd_retry(rd_retry), .wr_retry(wr_retry), .drain_req(drain_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // drive one request for one cycle; rdy = ready seen; pulses are visible on return
    task automatic send(input int addr, input bit wr, input int size, input bit inh, output bit rdy);
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(addr); req_is_write = wr;
        req_size = SZW'(size); req_inhibit = inh;
        #1 rdy = req_ready;
        @(negedge clk);
        req_valid = 1'b0; req_inhibit = 1'b0;
    endtask

    task automatic pulse_rd_pop();
        @(negedge clk); rdq_pop = 1'b1; @(negedge clk); rdq_pop = 1'b0;
    endtask

    task automatic pulse_resp_free();
        @(negedge clk); resp_free = 1'b1; @(negedge clk); resp_free = 1'b0;
    endtask

    task automatic pulse_wr_pop();
        @(negedge clk); wrq_pop = 1'b1; @(negedge clk); wrq_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit rdy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        eq("R12 rdq_valid", int'(rdq_valid), 0);
        eq("R12 wrq_valid", int'(wrq_valid), 0);
        eq("R12 drain_req", int'(drain_req), 0);
        eq("R12 pulses", int'({wr_ack, fwd_hit, req_err, rd_retry, wr_retry}), 0);

        // R7 illegal sizes, both directions
        for (int s = 0; s <= BURST + 4; s++) begin
            if (s == 0 || s > BURST) begin
                for (int w = 0; w < 2; w++) begin
                    send(32'h40 + s, w[0], s, 1'b0, rdy);
                    eq("R7 ready", int'(rdy), 1);
                    eq("R7 req_err", int'(req_err), 1);
                    eq("R7 no ack/fwd", int'({wr_ack, fwd_hit}), 0);
                end
            end
        end
        eq("R7 queues empty", int'({rdq_valid, wrq_valid}), 0);

        // R9 inhibited write and read
        send(16'h100, 1'b1, 4, 1'b1, rdy);
        eq("R9 ready", int'(rdy), 1);
        eq("R9 no pulses", int'({wr_ack, fwd_hit, req_err}), 0);
        send(16'h100, 1'b0, 4, 1'b1, rdy);
        eq("R9 no pulses rd", int'({wr_ack, fwd_hit, req_err}), 0);
        eq("R9 queues empty", int'({rdq_valid, wrq_valid}), 0);

        // R5/R12 writes after reset
        send(16'h100, 1'b1, BURST, 1'b0, rdy);
        eq("R12 write accepted", int'(rdy), 1);
        eq("R5 wr_ack", int'(wr_ack), 1);
        send(16'h200, 1'b1, 8, 1'b0, rdy);
        eq("R5 wr_ack 2", int'(wr_ack), 1);
        eq("R11 wr head", int'(wrq_addr), 16'h100);
        idle(2);
        eq("R6 no drain at threshold", int'(drain_req), 0);

        // R4 forward sweep over every byte of the burst and every legal size
        for (int k = 0; k < BURST; k++) begin
            send(16'h100 + k, 1'b0, k + 1, 1'b0, rdy);
            eq("R4 fwd ready", int'(rdy), 1);
            eq("R4 fwd_hit", int'(fwd_hit), 1);
            eq("R4 read queue untouched", int'(rdq_valid), 0);
        end
        send(16'h110, 1'b0, 4, 1'b0, rdy);
        eq("R4 next burst not forwarded", int'(fwd_hit), 0);
        eq("R4 next burst queued", int'(rdq_valid), 1);

        // R1 fill the read budget
        send(16'h300, 1'b0, 4, 1'b0, rdy);
        send(16'h310, 1'b0, 4, 1'b0, rdy);
        send(16'h320, 1'b0, 4, 1'b0, rdy);
        eq("R1 last fill accepted", int'(rdy), 1);
        send(16'h205, 1'b0, 2, 1'b0, rdy);
        eq("R4 forward while full", int'(rdy), 1);
        eq("R4 forward while full hit", int'(fwd_hit), 1);
        send(16'h400, 1'b0, 4, 1'b0, rdy);
        eq("R1 refuse when full", int'(rdy), 0);

        // R3 moving a read into the response stage keeps the budget full
        eq("R11 rd head", int'(rdq_addr), 16'h110);
        pulse_rd_pop();
        eq("R11 rd head next", int'(rdq_addr), 16'h300);
        send(16'h400, 1'b0, 4, 1'b0, rdy);
        eq("R3 still refused", int'(rdy), 0);

        // R8 retry on response slot free
        pulse_resp_free();
        eq("R8 rd_retry", int'(rd_retry), 1);
        pulse_rd_pop();
        pulse_resp_free();
        eq("R8 no second retry", int'(rd_retry), 0);
        send(16'h400, 1'b0, 4, 1'b0, rdy);
        eq("R3 accepted after room", int'(rdy), 1);

        // R6/R2 write side
        reads_paused = 1'b1;
        send(16'h500, 1'b1, 4, 1'b0, rdy);
        idle(2);
        eq("R6 paused no drain", int'(drain_req), 0);
        send(16'h600, 1'b1, 4, 1'b0, rdy);
        eq("R2 fourth write", int'(rdy), 1);
        send(16'h700, 1'b1, 4, 1'b0, rdy);
        eq("R2 refuse full", int'(rdy), 0);
        eq("R2 no ack", int'(wr_ack), 0);
        @(negedge clk); reads_paused = 1'b0;
        idle(2);
        eq("R6 drain starts", int'(drain_req), 1);

        eq("R11 wr head 0", int'(wrq_addr), 16'h100);
        pulse_wr_pop();
        eq("R10 wr_retry", int'(wr_retry), 1);
        send(16'h700, 1'b1, 4, 1'b0, rdy);
        eq("R3 write accepted after room", int'(rdy), 1);
        eq("R11 wr head 1", int'(wrq_addr), 16'h200);
        pulse_wr_pop();
        eq("R10 no second wretry", int'(wr_retry), 0);
        eq("R11 wr head 2", int'(wrq_addr), 16'h500);
        pulse_wr_pop();
        eq("R11 wr head 3", int'(wrq_addr), 16'h600);
        pulse_wr_pop();
        eq("R6 drain held", int'(drain_req), 1);
        eq("R11 wr head 4", int'(wrq_addr), 16'h700);
        pulse_wr_pop();
        eq("R11 write queue empty", int'(wrq_valid), 0);
        idle(2);
        eq("R6 drain ends", int'(drain_req), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule